// File: doc/BRIEF.md
# D-Channel Access Priority Controller

This block decides when a terminal sharing a basic-rate S-bus may begin sending a layer-2 frame on the D channel. A terminal with nothing to send transmits continuous 1s, and frame flags together with zero-bit insertion keep real traffic from producing long runs of 1s. A long enough run of 1s on the echo channel therefore shows that the channel is free. The block counts consecutive echoed 1s and grants access once the run reaches a threshold. The threshold depends on the requested priority class and on whether this terminal has recently completed a frame in that class.

While it transmits, the block compares every D bit it sends with the echo bit that returns. On the first mismatch it withdraws at once and starts counting again from zero. A Stop/Go status is produced for the layer-2 side, where 1 means stop and 0 means go. HDLC framing and the line interface sit outside this block.

Top module: `dch_access_ctrl`

## Requirements
- R1: After reset the block is waiting with the run count at zero and both classes at normal level: `grant` = 0, `abort` = 0, `stop_go` = 1.
- R2: On each cycle with `bit_stb` = 1 while waiting, an echoed 1 adds one to the consecutive-1 count and an echoed 0 clears it. The count saturates at 15 and never wraps.
- R3: While waiting with `frame_req` = 1, `grant` rises on the clock edge after a cycle in which the count is at least the threshold. The thresholds are: class 1 (`req_class` = 0) 8 at normal level and 9 when lowered; class 2 (`req_class` = 1) 10 at normal level and 11 when lowered.
- R4: A `frame_done` pulse while granted, with no collision in that cycle, drops `grant` on the next edge and puts the granted class at its lowered level.
- R5: While waiting with `frame_req` = 1 for a lowered class, a count that reaches that class's lowered threshold returns the class to normal level.
- R6: While granted, a cycle with `bit_stb` = 1 and `tx_d` ≠ `echo_e` raises `abort` in that same cycle, and `grant` is 0 from the next edge.
- R7: `stop_go` is 0 only while `grant` is 1 and `abort` is 0; in every other cycle it is 1.
- R8: When a collision and `frame_done` fall in the same cycle, the collision wins and the class level stays unchanged.
- R9: While waiting, `frame_done` and a mismatch between `tx_d` and `echo_e` have no effect: `abort` stays 0 and the grant timing is unchanged.
- R10: The count is held at zero while granted, so after a grant ends the full threshold must be counted again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe per D/E bit period |
| tx_d | input | 1 | D bit being transmitted in this bit period |
| echo_e | input | 1 | Echo bit received in this bit period |
| frame_req | input | 1 | A layer-2 frame is waiting to be sent |
| req_class | input | 1 | Priority class of the pending frame (0 = class 1, 1 = class 2) |
| frame_done | input | 1 | Pulse: the granted frame finished successfully |
| grant | output | 1 | Transmission allowed |
| abort | output | 1 | Collision detected in this bit period |
| stop_go | output | 1 | Stop/Go status (1 = stop, 0 = go) |

## Verification
A collision and a successful frame end can land in the same cycle while the block is granted. The bench provokes this by pulsing `frame_done` on the strobe where `tx_d` and `echo_e` differ. It then judges the result through the next grant: only the normal-level threshold of that class may be needed, which shows that no lowering took place. Restoring a class to normal level and granting can also happen on the same edge. This is checked by timing a lowered request against the lowered threshold and then timing the request that follows.

// File: rtl/dch_acc_pkg.sv
package dch_acc_pkg;
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_SEND = 1'b1
    } acc_state_e;
endpackage

// File: rtl/dch_echo_run.sv
module dch_echo_run #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             echo_e,
    input  logic             hold,
    output logic [CNT_W-1:0] run_o
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } run_t;

    run_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (hold) begin
            nxt_d.run = '0;
        end else if (bit_stb) begin
            if (!echo_e)                nxt_d.run = '0;
            else if (cur_q.run != SAT)  nxt_d.run = cur_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign run_o = cur_q.run;

    // R2: saturated count does not wrap
    p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.run == SAT && bit_stb && echo_e && !hold) |=> (cur_q.run == SAT));
    // R2: an echoed zero clears the run
    p_zero_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !echo_e) |=> (cur_q.run == '0));
    // R10: held at zero while sending
    p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cur_q.run == '0));
endmodule

// File: rtl/dch_prio_level.sv
module dch_prio_level #(
    parameter int BASE_THR   = 8,
    parameter int CLASS_STEP = 2,
    parameter int LOW_STEP   = 1,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_cls_i,
    input  logic             waiting_i,
    input  logic [CNT_W-1:0] run_i,
    input  logic             lower_i,
    input  logic             lower_cls_i,
    output logic [CNT_W-1:0] thr_o
);
    localparam int N_CLS = 2;

    typedef struct packed {
        logic [N_CLS-1:0] low;
    } lvl_t;

    lvl_t cur_q, nxt_d;

    logic [CNT_W-1:0] thr_n [N_CLS];
    logic [CNT_W-1:0] thr_l [N_CLS];
    logic [N_CLS-1:0] restore;
    logic [N_CLS-1:0] set_low;

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        localparam int TN = BASE_THR + c * CLASS_STEP;
        assign thr_n[c]   = CNT_W'(TN);
        assign thr_l[c]   = CNT_W'(TN + LOW_STEP);
        assign restore[c] = waiting_i && (req_cls_i == 1'(c)) && (run_i >= thr_l[c]);
        assign set_low[c] = lower_i && (lower_cls_i == 1'(c));

        // R4: successful frame lowers its class
        p_lower_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_low[c] |=> cur_q.low[c]);
        // R5: reaching the lowered threshold while waiting restores the class
        p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
            restore[c] |=> !cur_q.low[c]);
    end

    always_comb begin
        nxt_d = cur_q;
        for (int c = 0; c < N_CLS; c++) begin
            if (set_low[c])      nxt_d.low[c] = 1'b1;
            else if (restore[c]) nxt_d.low[c] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign thr_o = cur_q.low[req_cls_i] ? thr_l[req_cls_i] : thr_n[req_cls_i];
endmodule

// File: rtl/dch_access_fsm.sv
module dch_access_fsm
    import dch_acc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             tx_d,
    input  logic             echo_e,
    input  logic             req,
    input  logic             req_cls,
    input  logic             frame_done,
    input  logic [CNT_W-1:0] run_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             grant_o,
    output logic             abort_o,
    output logic             stop_go_o,
    output logic             lower_o,
    output logic             lower_cls_o,
    output logic             hold_o,
    output logic             waiting_o
);
    typedef struct packed {
        acc_state_e st;
        logic       cls;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic sending;

    assign sending     = (cur_q.st == ST_SEND);
    assign abort_o     = sending && bit_stb && (tx_d ^ echo_e);
    assign lower_o     = sending && frame_done && !abort_o;
    assign lower_cls_o = cur_q.cls;
    assign hold_o      = sending;
    assign waiting_o   = !sending && req;
    assign grant_o     = sending;
    assign stop_go_o   = !sending || abort_o;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_WAIT: begin
                if (req && (run_i >= thr_i)) begin
                    nxt_d.st  = ST_SEND;
                    nxt_d.cls = req_cls;
                end
            end
            ST_SEND: begin
                if (abort_o || frame_done) nxt_d.st = ST_WAIT;
            end
            default: nxt_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: ST_WAIT, cls: 1'b0};
        else        cur_q <= nxt_d;
    end

    // R6: collision ends the grant
    p_abort_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !grant_o);
    // R3: a grant only follows a count that met the threshold
    p_grant_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(req && (run_i >= thr_i)));
    // R8: a collision never lowers the class
    p_abort_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !lower_o);
    // R9: no abort while waiting
    p_no_abort_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_o |-> !abort_o);
endmodule

// File: rtl/dch_access_ctrl.sv
module dch_access_ctrl #(
    parameter int BASE_THR   = 8,
    parameter int CLASS_STEP = 2,
    parameter int LOW_STEP   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic tx_d,
    input  logic echo_e,
    input  logic frame_req,
    input  logic req_class,
    input  logic frame_done,
    output logic grant,
    output logic abort,
    output logic stop_go
);
    localparam int MAX_THR = BASE_THR + CLASS_STEP + LOW_STEP;
    localparam int CNT_W   = $clog2(MAX_THR + 1);

    logic [CNT_W-1:0] run_w;
    logic [CNT_W-1:0] thr_w;
    logic             hold_w;
    logic             waiting_w;
    logic             lower_w;
    logic             lower_cls_w;

    dch_echo_run #(.CNT_W(CNT_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .echo_e  (echo_e),
        .hold    (hold_w),
        .run_o   (run_w)
    );

    dch_prio_level #(
        .BASE_THR   (BASE_THR),
        .CLASS_STEP (CLASS_STEP),
        .LOW_STEP   (LOW_STEP),
        .CNT_W      (CNT_W)
    ) u_lvl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_cls_i   (req_class),
        .waiting_i   (waiting_w),
        .run_i       (run_w),
        .lower_i     (lower_w),
        .lower_cls_i (lower_cls_w),
        .thr_o       (thr_w)
    );

    dch_access_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .tx_d        (tx_d),
        .echo_e      (echo_e),
        .req         (frame_req),
        .req_cls     (req_class),
        .frame_done  (frame_done),
        .run_i       (run_w),
        .thr_i       (thr_w),
        .grant_o     (grant),
        .abort_o     (abort),
        .stop_go_o   (stop_go),
        .lower_o     (lower_w),
        .lower_cls_o (lower_cls_w),
        .hold_o      (hold_w),
        .waiting_o   (waiting_w)
    );

    // R7: after a grant ends the status reads stop
    p_stop_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant) |-> stop_go);
    // R10: the run restarts from zero after sending
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant) |-> (run_w <= CNT_W'(1)));
endmodule

// File: tb/dch_access_ctrl_test.sv
module dch_access_ctrl_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, stb, d, e, rq, rc, dn;
    logic grant, abort, stop_go;

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R1";

    int m_cnt;
    bit m_gr;
    bit m_cls;
    bit m_low [2];

    dch_access_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (stb),
        .tx_d       (d),
        .echo_e     (e),
        .frame_req  (rq),
        .req_class  (rc),
        .frame_done (dn),
        .grant      (grant),
        .abort      (abort),
        .stop_go    (stop_go)
    );

    task automatic chk(input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %0b exp %0b", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic s, input logic dd, input logic ee,
                        input logic r, input logic c, input logic f);
        int thr;
        bit ab;
        bit g;
        stb = s; d = dd; e = ee; rq = r; rc = c; dn = f;
        #1;
        ab = m_gr && s && (dd != ee);
        chk("grant", grant, m_gr);
        chk("abort(R6)", abort, ab);
        chk("stop_go(R7)", stop_go, !m_gr || ab);
        @(posedge clk);
        if (!m_gr) begin
            thr = 8 + 2 * int'(c) + (m_low[c] ? 1 : 0);
            g   = r && (m_cnt >= thr);
            if (r && (m_cnt >= 9 + 2 * int'(c))) m_low[c] = 1'b0;
            if (g) begin
                m_gr  = 1'b1;
                m_cls = c;
            end
            if (s) m_cnt = ee ? ((m_cnt < 15) ? m_cnt + 1 : 15) : 0;
        end else begin
            m_cnt = 0;
            if (ab) m_gr = 1'b0;
            else if (f) begin
                m_gr = 1'b0;
                m_low[m_cls] = 1'b1;
            end
        end
        @(negedge clk);
    endtask

    task automatic ones(input int n, input logic r, input logic c);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, r, c, 1'b0);
    endtask

    task automatic idle(input int n, input logic r, input logic c);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1, r, c, 1'b0);
    endtask

    initial begin
        #(4 * 50000);
        n_fail++;
        $display("FAIL watchdog R1 run hung got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stb = 0; d = 1; e = 1; rq = 0; rc = 0; dn = 0;
        m_cnt = 0; m_gr = 0; m_cls = 0; m_low[0] = 0; m_low[1] = 0;
        repeat (3) @(negedge clk);
        #1;
        tag = "R1";
        chk("reset grant", grant, 1'b0);
        chk("reset abort", abort, 1'b0);
        chk("reset stop_go", stop_go, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: class 1 normal grant after 8 ones
        tag = "R3";
        ones(7, 1, 0);
        idle(2, 1, 0);
        ones(1, 1, 0);
        idle(2, 1, 0);
        // R10: counting frozen while sending
        tag = "R10";
        ones(3, 1, 0);
        // R4: successful end lowers class 1
        tag = "R4";
        step(0, 1, 1, 0, 0, 1);
        idle(1, 0, 0);
        // R5: lowered class 1 needs 9, then restored
        tag = "R5";
        ones(8, 1, 0);
        idle(2, 1, 0);
        ones(1, 1, 0);
        idle(2, 1, 0);
        step(0, 1, 1, 0, 0, 1);
        // R2: an echoed zero restarts the run
        tag = "R2";
        ones(6, 1, 0);
        step(1, 1, 0, 1, 0, 0);
        ones(8, 1, 0);
        idle(1, 1, 0);
        ones(1, 1, 0);
        idle(2, 1, 0);
        step(0, 1, 1, 0, 0, 1);
        // R6: class 2 grant then collision
        tag = "R6";
        ones(10, 1, 1);
        idle(2, 1, 1);
        step(1, 1, 1, 1, 1, 0);
        step(1, 0, 1, 1, 1, 0);
        idle(1, 1, 1);
        // R10: full threshold from zero again
        tag = "R10";
        ones(9, 1, 1);
        idle(2, 1, 1);
        ones(1, 1, 1);
        idle(2, 1, 1);
        // R8: collision and frame end together
        tag = "R8";
        step(1, 1, 0, 1, 1, 1);
        idle(1, 0, 1);
        ones(9, 1, 1);
        idle(1, 1, 1);
        ones(1, 1, 1);
        idle(2, 1, 1);
        step(0, 1, 1, 0, 1, 1);
        // R9: waiting ignores frame end and mismatches
        tag = "R9";
        step(1, 0, 1, 0, 0, 1);
        step(1, 1, 0, 0, 0, 1);
        step(1, 0, 1, 1, 0, 0);
        step(0, 1, 1, 0, 0, 1);
        // R2: saturated run still grants lowered class 2
        tag = "R2";
        ones(20, 0, 0);
        idle(3, 1, 1);
        step(0, 1, 1, 0, 1, 1);
        // R3: sparse strobes, lowered class 1
        tag = "R3";
        for (int i = 0; i < 24; i++) step(1'(i % 2), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step(0, 1, 1, 0, 0, 1);
        idle(2, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule